// File: doc/BRIEF.md
# Transition and Refresh Pulse Encoder

This block drives the transmit end of a channel that carries a single logic level across a barrier as short pulses. It samples a synchronous data input once per clock and turns each change into a one-cycle pulse. A rise goes out on the set line and a fall goes out on the clear line. The receiving end is a bistable latch that only sees these pulses, so its state could drift if the input stays constant for a long time. To prevent this, the encoder repeats the current level whenever `REFRESH_CYCLES` clocks pass with no pulse sent.

Two inputs silence the channel. While `halt_in` is high or `pwr_ok` is low, no pulse of any kind is sent, and the receiver's own timeout moves its output to the safe low state. When the channel becomes active again, including the first cycle after reset, one pulse carrying the present input level goes out at once, so the far side resynchronises without waiting a full refresh interval.

With the default single input stage, an input sampled at one clock edge shows up on the outputs after the next edge.

Top module: `iso_pulse_encoder`

## Requirements
- R1: While `rst` is high and on the first clock after its release, `set_pulse` and `clr_pulse` are both 0.
- R2: When `data_in` changes from 0 to 1 while active, `set_pulse` is high for exactly the one cycle that follows the edge that sampled the new value.
- R3: When `data_in` changes from 1 to 0 while active, `clr_pulse` is high for exactly the one cycle that follows the edge that sampled the new value.
- R4: After `REFRESH_CYCLES` cycles with no pulse while active, a refresh pulse goes out that encodes the level: set if `data_in` is 1, clear if it is 0.
- R5: While the input stays constant and active, refresh pulses repeat with a period of exactly `REFRESH_CYCLES` cycles.
- R6: `set_pulse` and `clr_pulse` are never high in the same cycle.
- R7: Neither output is high for two consecutive cycles when the input is held steady. `REFRESH_CYCLES` must be at least 2.
- R8: The channel is active only when `halt_in` is 0 and `pwr_ok` is 1. Starting with the second cycle after it becomes inactive, no pulse is sent, whatever `data_in` does.
- R9: When the channel becomes active, a level pulse for the current `data_in` goes out in the cycle after the edge that samples the active state.
- R10: Every pulse restarts the idle interval. An edge that arrives in the same cycle that a refresh falls due produces a single pulse with the new level, and the next refresh follows `REFRESH_CYCLES` cycles later.
- R11: An input that toggles on every clock is encoded without loss, as one pulse per change in alternating directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Synchronous logic level to transmit |
| halt_in | input | 1 | High stops all pulse generation |
| pwr_ok | input | 1 | Low stops all pulse generation (supply not good) |
| set_pulse | output | 1 | One-cycle pulse meaning "level is high" |
| clr_pulse | output | 1 | One-cycle pulse meaning "level is low" |

## Verification
An input edge and an expiring refresh count can fall in the same cycle. The bench provokes this by changing `data_in` exactly `REFRESH_CYCLES` cycles after the last pulse. It judges the outcome by requiring one pulse carrying the new level, with no stale refresh of the old level around it and the next refresh a full interval later. A resume can likewise coincide with an input change made while halted. There the bench expects a single level pulse rather than two.

// File: rtl/iso_enc_pkg.sv
package iso_enc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_EDGE    = 2'd1,
    CAUSE_RESUME  = 2'd2,
    CAUSE_REFRESH = 2'd3
  } cause_t;

  function automatic cause_t pick_cause(input logic changed,
                                        input logic resumed,
                                        input logic due);
    if (changed)      return CAUSE_EDGE;
    else if (resumed) return CAUSE_RESUME;
    else if (due)     return CAUSE_REFRESH;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/iso_enc_input_stage.sv
module iso_enc_input_stage #(
  parameter int IN_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic halt_in,
  input  logic pwr_ok,
  output logic lvl_q,
  output logic lvl_prev,
  output logic act_q,
  output logic act_prev
);

  logic [IN_STAGES-1:0] pipe;

  generate
    if (IN_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[IN_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= 1'b0;
      act_q    <= 1'b0;
      act_prev <= 1'b0;
    end else begin
      lvl_prev <= pipe[IN_STAGES-1];
      act_q    <= ~halt_in & pwr_ok;
      act_prev <= act_q;
    end
  end

  assign lvl_q = pipe[IN_STAGES-1];

endmodule

// File: rtl/iso_enc_idle_timer.sv
module iso_enc_idle_timer #(
  parameter int REFRESH_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic due
);

  localparam int CW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign due = run && (cnt == LAST);

  AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == LAST) |=> (cnt == '0)); // R5

endmodule

// File: rtl/iso_enc_pulse_gen.sv
module iso_enc_pulse_gen
  import iso_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_q,
  input  logic lvl_prev,
  input  logic act_q,
  input  logic act_prev,
  input  logic due,
  output logic fire,
  output logic set_o,
  output logic clr_o
);

  cause_t cause;
  logic   changed;
  logic   resumed;

  assign changed = act_q && (lvl_q != lvl_prev);
  assign resumed = act_q && !act_prev;
  assign cause   = pick_cause(changed, resumed, due);
  assign fire    = act_q && (cause != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      set_o <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      set_o <= fire &&  lvl_q;
      clr_o <= fire && !lvl_q;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(set_o && clr_o)); // R6

  AST_SET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (set_o && $stable(lvl_q)) |=> !set_o); // R7

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (clr_o && $stable(lvl_q)) |=> !clr_o); // R7

  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (act_q && lvl_q != lvl_prev) |=> (set_o == $past(lvl_q)) && (clr_o != $past(lvl_q))); // R2

endmodule

// File: rtl/iso_pulse_encoder.sv
module iso_pulse_encoder #(
  parameter int REFRESH_CYCLES = 100,
  parameter int IN_STAGES      = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic halt_in,
  input  logic pwr_ok,
  output logic set_pulse,
  output logic clr_pulse
);

  logic lvl_q, lvl_prev, act_q, act_prev;
  logic due, fire;

  iso_enc_input_stage #(.IN_STAGES(IN_STAGES)) u_in (
    .clk      (clk),
    .rst      (rst),
    .din      (data_in),
    .halt_in  (halt_in),
    .pwr_ok   (pwr_ok),
    .lvl_q    (lvl_q),
    .lvl_prev (lvl_prev),
    .act_q    (act_q),
    .act_prev (act_prev)
  );

  iso_enc_idle_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (act_q),
    .restart (fire),
    .due     (due)
  );

  iso_enc_pulse_gen u_gen (
    .clk      (clk),
    .rst      (rst),
    .lvl_q    (lvl_q),
    .lvl_prev (lvl_prev),
    .act_q    (act_q),
    .act_prev (act_prev),
    .due      (due),
    .fire     (fire),
    .set_o    (set_pulse),
    .clr_o    (clr_pulse)
  );

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    $past(halt_in || !pwr_ok, 2) |-> !(set_pulse || clr_pulse)); // R8

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
    (act_q && !act_prev) |=> (set_pulse || clr_pulse)); // R9

endmodule

// File: tb/test_iso_pulse_encoder.sv
module test_iso_pulse_encoder;

  localparam int TB_R  = 8;
  localparam int NVEC  = 30;
  // {data_in, halt_in, pwr_ok, exp_set, exp_clr}; expectation reflects previous row's inputs
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00100, 5'b00101, 5'b10100, 5'b00110, 5'b00101,
    5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
    5'b00100, 5'b00100, 5'b00101, 5'b00100, 5'b00100,
    5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b10100,
    5'b10110, 5'b10100, 5'b11100, 5'b11100, 5'b01100,
    5'b01100, 5'b00100, 5'b00101, 5'b00100, 5'b00100
  };

  logic clk = 1'b0;
  logic rst, data_in, halt_in, pwr_ok;
  logic set_pulse, clr_pulse;
  int   checks = 0;
  int   fails  = 0;

  always #10 clk = ~clk;

  iso_pulse_encoder #(.REFRESH_CYCLES(TB_R)) i_iso_pulse_encoder (
    .clk(clk), .rst(rst), .data_in(data_in), .halt_in(halt_in),
    .pwr_ok(pwr_ok), .set_pulse(set_pulse), .clr_pulse(clr_pulse)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {set,clr} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      3:       return "R2";
      4:       return "R3";
      12:      return "R4";
      20:      return "R10";
      22, 23, 24, 25, 26: return "R8";
      27:      return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
    $finish;
  end

  initial begin
    logic pchg, plvl;
    rst = 1'b1; data_in = 1'b0; halt_in = 1'b0; pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {set_pulse, clr_pulse}, 2'b00);
    rst = 1'b0;

    // vector table: startup resume, edges, refresh, edge on refresh, halt, resume
    for (int i = 0; i < NVEC; i++) begin
      data_in = VEC[i][4]; halt_in = VEC[i][3]; pwr_ok = VEC[i][2];
      @(negedge clk);
      chk($sformatf("%s row%0d", row_tag(i), i), {set_pulse, clr_pulse}, VEC[i][1:0]);
    end

    // refresh train at level 1: pulses at k=2, 2+R, 2+2R
    data_in = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      logic es;
      @(negedge clk);
      es = (k >= 2) && (((k - 2) % TB_R) == 0);
      chk(k > 2 ? "R5 train" : "R7 train", {set_pulse, clr_pulse}, {es, 1'b0});
    end

    // toggle every clock: one pulse per change
    pchg = 1'b0; plvl = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic nd, chg;
      nd  = (k < 6) ? ~data_in : data_in;
      chg = (nd != data_in);
      data_in = nd;
      @(negedge clk);
      chk(plvl ? "R11 R2 toggle" : "R11 R3 toggle", {set_pulse, clr_pulse},
          {pchg & plvl, pchg & ~plvl});
      pchg = chg; plvl = nd;
    end

    // supply not good: silent despite input activity
    pwr_ok = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 0) data_in = ~data_in;
      @(negedge clk);
      chk("R8 pwr_ok low", {set_pulse, clr_pulse}, 2'b00);
    end

    // supply returns: level pulse on second edge
    pwr_ok = 1'b1;
    @(negedge clk);
    chk("R9 resume first", {set_pulse, clr_pulse}, 2'b00);
    @(negedge clk);
    chk("R9 resume pulse", {set_pulse, clr_pulse}, {data_in, ~data_in});
    @(negedge clk);
    chk("R7 after resume", {set_pulse, clr_pulse}, 2'b00);

    // reset in the middle of activity
    data_in = ~data_in;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", {set_pulse, clr_pulse}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {set_pulse, clr_pulse}, 2'b00);

    report();
    $finish;
  end

endmodule